// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel. It advances on a one-cycle count-enable input (`tick`) instead of a dedicated clock. It counts either in plain binary or in four-digit packed BCD. Six operating modes set the shape of the `out` waveform, decide whether the count reloads when it ends, and decide whether the `gate` input works as a level (pause and resume) or as a rising edge (restart). Another block decodes the control word and sequences the host byte accesses. That block presents a complete initial count with a one-cycle `load` strobe, together with the mode and number system. This channel exposes the live count, the `out` waveform and a one-cycle `tc_pulse` that can be used as an interrupt request.

The channel has one controlling state machine:

- `ST_IDLE`: reset state. No count has been loaded yet.
- `ST_ARMED`: a load or a gate restart is waiting for the next tick.
- `ST_RUN`: counting, terminal count not yet reached.
- `ST_SETTLED`: a one-shot mode has passed its terminal count. Counting goes on and wraps.

Transitions:

- IDLE→ARMED on `load`.
- ARMED→RUN on a later `tick` with no `load` in the same cycle.
- RUN→ARMED and SETTLED→ARMED on `load`, or on a gate rising edge in modes 1, 2, 3 and 5.
- RUN→SETTLED when a counted tick brings the count to zero in modes 0, 1, 4 and 5.

A zero initial count stands for the largest count. In binary the count wraps from 0 to FFFF. In BCD it wraps from 0000 to 9999. A zero load therefore spans 65536 or 10000 ticks.

Top module: `ict_channel`

## Requirements
- R1: From reset until the first `load`, `count` is 0, `out` and `tc_pulse` are low, and ticks have no effect.
- R2: A `load` strobe captures `load_value`, `mode_sel` and `bcd_sel` and leaves `count` unchanged. On the next tick in a later cycle, `count` becomes the loaded value. `out` starts high in modes 1 and 3 and low in every other mode. `count` changes only in cycles that follow a tick.
- R3: In binary (`bcd_sel`=0) the count decrements by one per counted tick and wraps from 0000 to FFFF. A load of 0 reads 0000 after the reload tick and FFFF one tick later.
- R4: In BCD (`bcd_sel`=1) each 4-bit nibble is a decimal digit (bits 3:0 ones, bits 15:12 thousands). A decrement borrows from the next digit when a digit passes from 0 to 9, and 0000 wraps to 9999. A load of 0 gives a 10000-tick period.
- R5: Mode 0 (`mode_sel`=0): `out` rises and `tc_pulse` pulses for one cycle on the tick that brings the count to 0. `out` then stays high while the count keeps wrapping.
- R6: Mode 1: `out` is high from the reload tick until the tick that brings the count to 0, then low and stays low.
- R7: Mode 2: the count runs N, N-1, ..., 1. On the tick taken at count 1 it reloads N, `out` goes high until the next tick and `tc_pulse` fires. `out` is low on the reload that follows a load.
- R8: Mode 3: the count runs N..1 and then reloads. `out` is high while the count's magnitude (0 meaning 65536 or 10000) exceeds floor(N/2), which is the first (N+1)/2 ticks of each period. `tc_pulse` fires on every periodic reload.
- R9: Modes 4 and 5: `out` is high for exactly one tick interval, starting at the tick that first brings the count to 0. `tc_pulse` stays low.
- R10: In modes 0 and 4, a tick while `gate` is low leaves `count` unchanged.
- R11: In modes 1, 2, 3 and 5 the level of `gate` does not stop counting. A rising edge of `gate` after the first load makes the next tick reload the initial count and restore the starting `out` level.
- R12: `mode_sel` values 6 and 7 behave as modes 2 and 3.
- R13: `tc_pulse` is asserted only in modes 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count-enable strobe |
| load | input | 1 | One-cycle strobe that captures a new initial count and mode |
| load_value | input | 16 | Initial count, binary or packed BCD |
| mode_sel | input | 3 | Operating mode 0..7 (6 and 7 alias 2 and 3) |
| bcd_sel | input | 1 | 1 selects BCD counting |
| gate | input | 1 | Gate: level in modes 0 and 4, rising edge in the other modes |
| count | output | 16 | Current count |
| out | output | 1 | Mode-shaped output waveform |
| tc_pulse | output | 1 | One-cycle terminal-count event in modes 0, 2 and 3 |

## Verification
The bench targets the borrow chain at the BCD boundaries: 0100→0099, and 0000→9999 over a full 10000-tick zero-load period. A faulty borrow chain would show a hex digit such as 00FF or would stop early. It checks that a zero load spans the full period, not zero ticks, and that mode 2 does not pulse on the reload right after a load. It checks that mode 3 with an odd count holds `out` high for the longer half, where an off-by-one threshold gives a symmetric wave. It also checks that a gate edge restarts only the edge modes, that a low gate freezes only modes 0 and 4, and that the aliased codes 6 and 7 do not fall into the one-shot behaviour.

// File: rtl/ict_pkg.sv
package ict_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_RUN     = 2'd2,
        ST_SETTLED = 2'd3
    } ict_state_e;

    typedef enum logic [2:0] {
        M_END_LATCH     = 3'd0,
        M_RETRIG_WINDOW = 3'd1,
        M_RATE          = 3'd2,
        M_SQUARE        = 3'd3,
        M_SOFT_STROBE   = 3'd4,
        M_HARD_STROBE   = 3'd5
    } ict_mode_e;

    function automatic ict_mode_e fold_mode(input logic [2:0] m);
        if (m[2:1] == 2'b11)
            return ict_mode_e'({1'b0, m[1:0]});
        return ict_mode_e'(m);
    endfunction

    function automatic logic start_level(input ict_mode_e m);
        return (m == M_RETRIG_WINDOW) || (m == M_SQUARE);
    endfunction

    function automatic longint unsigned pow10(input int n);
        longint unsigned r;
        r = 1;
        for (int k = 0; k < n; k++)
            r = r * 10;
        return r;
    endfunction

endpackage

// File: rtl/ict_decrement.sv
module ict_decrement #(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic [W-1:0] value_i,
    input  logic         bcd_i,
    output logic [W-1:0] value_o
);

    logic [DIGITS-1:0] borrow;
    logic [W-1:0]      bcd_res;

    assign borrow[0] = 1'b1;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] dig;
        assign dig = value_i[4*i +: 4];
        assign bcd_res[4*i +: 4] = !borrow[i] ? dig :
                                   (dig == 4'd0) ? 4'd9 : dig - 4'd1;
        if (i + 1 < DIGITS) begin : g_chain
            assign borrow[i+1] = borrow[i] && (dig == 4'd0);
        end
    end

    assign value_o = bcd_i ? bcd_res : value_i - W'(1);

endmodule

// File: rtl/ict_weight.sv
module ict_weight
    import ict_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W  = 4 * DIGITS,
    localparam int WB = W + 1
) (
    input  logic [W-1:0]  value_i,
    input  logic          bcd_i,
    output logic [WB-1:0] weight_o
);

    localparam logic [WB-1:0] FULL_BIN = WB'(1) << W;
    localparam logic [WB-1:0] FULL_BCD = WB'(pow10(DIGITS));

    logic [WB-1:0] partial [DIGITS+1];

    assign partial[0] = '0;

    for (genvar i = 0; i < DIGITS; i++) begin : g_sum
        assign partial[i+1] = partial[i]
                            + WB'(value_i[4*i +: 4]) * WB'(pow10(i));
    end

    always_comb begin
        if (value_i == '0)
            weight_o = bcd_i ? FULL_BCD : FULL_BIN;
        else if (bcd_i)
            weight_o = partial[DIGITS];
        else
            weight_o = {1'b0, value_i};
    end

endmodule

// File: rtl/ict_edge.sv
module ict_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sig_i;
    end

    assign rise_o = sig_i && !prev_q;

endmodule

// File: rtl/ict_channel.sv
module ict_channel
    import ict_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int W = 4 * DIGITS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_value,
    input  logic [2:0]   mode_sel,
    input  logic         bcd_sel,
    input  logic         gate,
    output logic [W-1:0] count,
    output logic         out,
    output logic         tc_pulse
);

    localparam int WB = W + 1;

    ict_state_e    state_q, state_d;
    ict_mode_e     mode_q;
    logic          bcd_q;
    logic [W-1:0]  init_q, count_q, dec_val, count_nxt;
    logic [WB-1:0] w_next, w_init;
    logic          out_q, tc_q, gate_rise;
    logic          level_mode, periodic, active, restart, cnt_en;
    logic          wrap_point, dec_zero;

    ict_decrement #(.DIGITS(DIGITS)) u_dec (
        .value_i(count_q), .bcd_i(bcd_q), .value_o(dec_val)
    );

    ict_weight #(.DIGITS(DIGITS)) u_w_next (
        .value_i(count_nxt), .bcd_i(bcd_q), .weight_o(w_next)
    );

    ict_weight #(.DIGITS(DIGITS)) u_w_init (
        .value_i(init_q), .bcd_i(bcd_q), .weight_o(w_init)
    );

    ict_edge u_gate (
        .clk(clk), .rst_n(rst_n), .sig_i(gate), .rise_o(gate_rise)
    );

    assign level_mode = (mode_q == M_END_LATCH) || (mode_q == M_SOFT_STROBE);
    assign periodic   = (mode_q == M_RATE) || (mode_q == M_SQUARE);
    assign active     = (state_q == ST_RUN) || (state_q == ST_SETTLED);
    assign restart    = gate_rise && !level_mode && (state_q != ST_IDLE);
    assign cnt_en     = tick && (gate || !level_mode);
    assign wrap_point = (count_q == W'(1));
    assign dec_zero   = (dec_val == '0);
    assign count_nxt  = (periodic && wrap_point) ? init_q : dec_val;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (load) state_d = ST_ARMED;
            ST_ARMED:   if (!load && tick) state_d = ST_RUN;
            ST_RUN: begin
                if (load || restart)
                    state_d = ST_ARMED;
                else if (cnt_en && dec_zero && !periodic)
                    state_d = ST_SETTLED;
            end
            ST_SETTLED: if (load || restart) state_d = ST_ARMED;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // counter, configuration and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q  <= '0;
            count_q <= '0;
            mode_q  <= M_END_LATCH;
            bcd_q   <= 1'b0;
            out_q   <= 1'b0;
            tc_q    <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            if (load) begin
                init_q <= load_value;
                mode_q <= fold_mode(mode_sel);
                bcd_q  <= bcd_sel;
            end
            if (state_q == ST_ARMED && tick && !load) begin
                count_q <= init_q;
                out_q   <= start_level(mode_q);
            end else if (active && !load && !restart && cnt_en) begin
                count_q <= count_nxt;
                case (mode_q)
                    M_RATE: begin
                        out_q <= wrap_point;
                        tc_q  <= wrap_point;
                    end
                    M_SQUARE: begin
                        out_q <= (w_next > (w_init >> 1));
                        tc_q  <= wrap_point;
                    end
                    M_END_LATCH: begin
                        if (state_q == ST_RUN && dec_zero) begin
                            out_q <= 1'b1;
                            tc_q  <= 1'b1;
                        end
                    end
                    M_RETRIG_WINDOW: begin
                        if (state_q == ST_RUN && dec_zero)
                            out_q <= 1'b0;
                    end
                    default: out_q <= (state_q == ST_RUN) && dec_zero;
                endcase
            end
        end
    end

    assign count    = count_q;
    assign out      = out_q;
    assign tc_pulse = tc_q;

    // R1: nothing is produced before the first load
    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!out_q && !tc_q));

    // R2: the count moves only in the cycle after a tick
    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count_q));

    // R10: a low gate freezes the level-gated modes
    p_level_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !gate && !load && active &&
         (mode_q == M_END_LATCH || mode_q == M_SOFT_STROBE)) |=> $stable(count_q));

    // R13: the event only appears in modes 0, 2 and 3
    p_tc_modes_r13: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |-> (mode_q inside {M_END_LATCH, M_RATE, M_SQUARE}));

    // R5: once settled in mode 0, out stays high
    p_latch_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLED && mode_q == M_END_LATCH &&
         $past(state_q == ST_SETTLED)) |-> out_q);

endmodule

// File: tb/ict_channel_tb.sv
module ict_channel_tb;

    logic        clk = 1'b0;
    logic        rst_n, tick, load, bcd_sel, gate;
    logic [15:0] load_value;
    logic [2:0]  mode_sel;
    logic [15:0] count;
    logic        out, tc_pulse;

    always #5 clk = ~clk;

    ict_channel u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_value(load_value), .mode_sel(mode_sel), .bcd_sel(bcd_sel),
        .gate(gate), .count(count), .out(out), .tc_pulse(tc_pulse)
    );

    typedef struct {
        int          stamp;
        logic [15:0] c;
        logic        o;
        logic        t;
        string       rq;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc++;

    task automatic compare(input item_t it);
        n_vec++;
        if (count !== it.c || out !== it.o || tc_pulse !== it.t) begin
            n_bad++;
            $display("FAIL %s: actual count=%h out=%b tc=%b expected count=%h out=%b tc=%b",
                     it.rq, count, out, tc_pulse, it.c, it.o, it.t);
        end
    endtask

    // monitor: pops items whose tick edge has passed
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].stamp < cyc) begin
            item_t it;
            it = sb.pop_front();
            compare(it);
        end
    end

    // driver: one tick, expected result queued
    task automatic tk(input logic [15:0] c, input logic o, input logic t, input string rq);
        @(negedge clk);
        tick = 1'b1;
        sb.push_back('{cyc, c, o, t, rq});
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ld(input logic [15:0] v, input logic [2:0] m, input logic b);
        @(negedge clk);
        load = 1'b1; load_value = v; mode_sel = m; bcd_sel = b;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic gt(input logic v);
        @(negedge clk);
        gate = v;
        @(negedge clk);
    endtask

    task automatic direct(input logic [15:0] c, input logic o, input logic t, input string rq);
        @(negedge clk);
        compare('{0, c, o, t, rq});
    endtask

    function automatic logic [15:0] to_bcd(input int v);
        logic [15:0] r;
        r = '0;
        for (int d = 0; d < 4; d++) begin
            r[4*d +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual run still busy expected run finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; load = 1'b0; gate = 1'b1;
        load_value = '0; mode_sel = '0; bcd_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, ticks ignored before a load
        direct(16'h0000, 0, 0, "R1");
        tk(16'h0000, 0, 0, "R1");

        // R2 / R5 / R3 mode 0 binary
        ld(16'd3, 3'd0, 0);
        direct(16'h0000, 0, 0, "R2");
        tk(16'd3, 0, 0, "R2");
        tk(16'd2, 0, 0, "R5");
        tk(16'd1, 0, 0, "R5");
        tk(16'd0, 1, 1, "R5");
        tk(16'hFFFF, 1, 0, "R3");

        // R10 mode 0 gate level
        ld(16'd2, 3'd0, 0);
        tk(16'd2, 0, 0, "R2");
        gt(0);
        tk(16'd2, 0, 0, "R10");
        gt(1);
        tk(16'd1, 0, 0, "R10");
        tk(16'd0, 1, 1, "R5");

        // R6 mode 1, R11 gate restart
        ld(16'd2, 3'd1, 0);
        tk(16'd2, 1, 0, "R6");
        tk(16'd1, 1, 0, "R6");
        tk(16'd0, 0, 0, "R6");
        tk(16'hFFFF, 0, 0, "R6");
        gt(0); gt(1);
        tk(16'd2, 1, 0, "R11");
        gt(0);
        tk(16'd1, 1, 0, "R11");
        gt(1);
        tk(16'd2, 1, 0, "R11");

        // R7 mode 2
        ld(16'd3, 3'd2, 0);
        tk(16'd3, 0, 0, "R7");
        tk(16'd2, 0, 0, "R7");
        tk(16'd1, 0, 0, "R7");
        tk(16'd3, 1, 1, "R7");
        tk(16'd2, 0, 0, "R7");
        tk(16'd1, 0, 0, "R7");
        tk(16'd3, 1, 1, "R7");

        // R12 mode 6 behaves as 2
        ld(16'd2, 3'd6, 0);
        tk(16'd2, 0, 0, "R12");
        tk(16'd1, 0, 0, "R12");
        tk(16'd2, 1, 1, "R12");

        // R8 mode 3 odd count
        ld(16'd5, 3'd3, 0);
        tk(16'd5, 1, 0, "R8");
        tk(16'd4, 1, 0, "R8");
        tk(16'd3, 1, 0, "R8");
        tk(16'd2, 0, 0, "R8");
        tk(16'd1, 0, 0, "R8");
        tk(16'd5, 1, 1, "R8");
        tk(16'd4, 1, 0, "R8");

        // R12 mode 7 behaves as 3
        ld(16'd4, 3'd7, 0);
        tk(16'd4, 1, 0, "R12");
        tk(16'd3, 1, 0, "R12");
        tk(16'd2, 0, 0, "R12");
        tk(16'd1, 0, 0, "R12");
        tk(16'd4, 1, 1, "R12");

        // R9 / R13 mode 4, R10 gate level
        ld(16'd2, 3'd4, 0);
        tk(16'd2, 0, 0, "R9");
        tk(16'd1, 0, 0, "R9");
        tk(16'd0, 1, 0, "R13");
        tk(16'hFFFF, 0, 0, "R9");
        gt(0);
        tk(16'hFFFF, 0, 0, "R10");
        gt(1);

        // R9 mode 5 with R11 restart
        ld(16'd1, 3'd5, 0);
        tk(16'd1, 0, 0, "R9");
        tk(16'd0, 1, 0, "R9");
        tk(16'hFFFF, 0, 0, "R9");
        gt(0); gt(1);
        tk(16'd1, 0, 0, "R11");
        tk(16'd0, 1, 0, "R13");

        // R4 BCD borrow and wrap
        ld(16'h0100, 3'd0, 1);
        tk(16'h0100, 0, 0, "R4");
        tk(16'h0099, 0, 0, "R4");
        ld(16'h0000, 3'd0, 1);
        tk(16'h0000, 0, 0, "R4");
        tk(16'h9999, 0, 0, "R4");

        // R3 binary zero load wraps
        ld(16'h0000, 3'd2, 0);
        tk(16'h0000, 0, 0, "R3");
        tk(16'hFFFF, 0, 0, "R3");

        // R4 / R7 BCD zero load: full 10000-tick period
        ld(16'h0000, 3'd2, 1);
        tk(16'h0000, 0, 0, "R7");
        for (int k = 1; k < 10000; k++)
            tk(to_bcd(10000 - k), 0, 0, "R4");
        tk(16'h0000, 1, 1, "R4");

        // R8 BCD square wave, count ten
        ld(16'h0010, 3'd3, 1);
        tk(16'h0010, 1, 0, "R8");
        for (int k = 1; k < 10; k++)
            tk(to_bcd(10 - k), (10 - k) > 5, 0, "R8");
        tk(16'h0010, 1, 1, "R8");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule